// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR graphics SDRAM and brings the memory from reset to normal operation. It holds the clock-enable pin low while the clock settles for a configurable number of microseconds, then raises it. It then issues a fixed series of commands: precharge of all banks, an extended mode write that enables the DLL, a mode write that resets the DLL, a second precharge, a configurable number of auto-refreshes, and a final mode write with the DLL-reset bit cleared. Each command is separated from the next by the required number of clocks, and NOP is driven in every gap. A done flag rises once the final mode write has settled and the DLL has had its lock time.

The clock period is a parameter, and the settling interval is converted to clock cycles from it. Burst length, burst type and output drive strength come from input pins that are captured once, on the first clock edge after reset is released. After the flag is up, a relock request repeats the DLL-reset part of the sequence, which the memory needs after its operating frequency has changed. The reset input is expected to be released in step with the clock.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, clock enable is 0, the command pins show NOP, address and bank lines are 0, and the done flag is 0.
- R2: Clock enable stays 0 for S = ceil(STABLE_US*10^6 / CLK_PERIOD_PS) clock edges after reset release and rises at edge S. From then on it stays 1 until the next reset.
- R3: Command pins {cs_n, ras_n, cas_n, we_n} encode NOP as 0111, precharge as 0010, auto-refresh as 0001 and mode write as 0000. Every cycle without a command is NOP with address and bank at 0.
- R4: Commands are issued in this order and at these edges: precharge-all (A10=1, all other address and bank bits 0) at edge S+1; extended write T_RP later; DLL-reset mode write T_MRD later; precharge-all T_MRD later; the first refresh T_RP later; further refreshes T_RFC apart, N_REF in total; the final mode write T_RFC after the last refresh.
- R5: The extended write drives bank=01, A0=0 (DLL on), A1=drive[0], A6=drive[1], and all other address bits 0. A drive code of 11 is replaced by 00.
- R6: Normal mode writes drive bank=00, A2..A0 = burst length code (001=2, 010=4, 011=8), A3 = burst type (1=interleave), A6..A4=011 (latency 3), A7=0, and A8=1 for the DLL-reset write or 0 for the final write. All other bits are 0.
- R7: A burst length code other than 001, 010 or 011 is replaced by 010, and the burst type is then forced to sequential.
- R8: The done flag rises at edge max(F+T_MRD, D+LOCK_CYC), where F is the edge of the final mode write and D the edge of the DLL-reset write. While it is high, only NOPs are issued.
- R9: The configuration pins are sampled only at the first edge after reset release. Later changes have no effect on any mode word.
- R10: A relock request seen at edge q while done is high drops done at edge q and issues the DLL-reset mode write at edge q+1. It then follows the R4 tail (precharge, refreshes, final write) and the R8 completion rule. The extended write is not repeated, and clock enable stays high.
- R11: A relock request seen while done is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| relock_req | input | 1 | Request to redo the DLL reset and lock wait |
| cfg_burst_len | input | 3 | Burst length code, sampled after reset |
| cfg_burst_ilv | input | 1 | Burst type, 1 = interleave |
| cfg_drive | input | 2 | Drive strength code {A6, A1} |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank select |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Normal operation may begin |

## Verification
All outputs are registered, so each result shows up exactly at the edge that R2, R4, R8 and R10 name. For example, clock enable appears at edge S and the first precharge at S+1. A relock seen at edge q clears done at q and puts the mode write on the pins at q+1. The reference model turns these edge formulas into a schedule of expected commands indexed by the edge count since reset release. It samples every output 2 ns after each rising edge, so values are read once they have settled and before the next edge. Requests that must be ignored (late configuration changes, an early relock) leave the schedule untouched, so any effect they had would appear as a mismatch on the pins.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_CKE_UP,
    ST_PRE1,
    ST_EXT,
    ST_MODE_RST,
    ST_PRE2,
    ST_REFRESH,
    ST_MODE_RUN,
    ST_LOCK,
    ST_DONE
  } boot_state_e;

  typedef enum logic [1:0] {
    W_PRE,
    W_EXT,
    W_MODE_RST,
    W_MODE_RUN
  } word_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/boot_timer.sv
`timescale 1ns/1ps
module boot_timer #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/boot_mode_enc.sv
`timescale 1ns/1ps
module boot_mode_enc
  import boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  word_e             sel_i,
  input  logic [2:0]        bl_i,
  input  logic              bt_i,
  input  logic [1:0]        drv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  always_comb begin
    addr_o = '0;
    ba_o   = '0;
    unique case (sel_i)
      W_PRE: addr_o[10] = 1'b1;
      W_EXT: begin
        ba_o      = BA_W'(1);
        addr_o[1] = drv_i[0];
        addr_o[6] = drv_i[1];
      end
      W_MODE_RST, W_MODE_RUN: begin
        addr_o[2:0] = bl_i;
        addr_o[3]   = bt_i;
        addr_o[6:4] = 3'b011;
        addr_o[8]   = (sel_i == W_MODE_RST);
      end
      default: addr_o = '0;
    endcase
  end

endmodule

// File: rtl/sdram_boot_seq.sv
`timescale 1ns/1ps
module sdram_boot_seq
  import boot_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned STABLE_US     = 200,
  parameter int unsigned T_RP          = 4,
  parameter int unsigned T_RFC         = 14,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned LOCK_CYC      = 200,
  parameter int unsigned N_REF         = 2,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              relock_req,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_ilv,
  input  logic [1:0]        cfg_drive,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned STABLE_CYC = (STABLE_US * 1000000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned CNT_MAX    = (STABLE_CYC > LOCK_CYC) ? STABLE_CYC : LOCK_CYC;
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
  localparam int unsigned REF_W      = $clog2(N_REF + 1);

  // configuration capture on the first edge after reset
  logic       cap_q;
  logic [2:0] bl_q, bl_fix;
  logic       bt_q, bt_fix, bl_ok;
  logic [1:0] drv_q, drv_fix;

  assign bl_ok   = (cfg_burst_len == 3'd1) || (cfg_burst_len == 3'd2) || (cfg_burst_len == 3'd3);
  assign bl_fix  = bl_ok ? cfg_burst_len : 3'd2;
  assign bt_fix  = bl_ok & cfg_burst_ilv;
  assign drv_fix = (cfg_drive == 2'b11) ? 2'b00 : cfg_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b1;
      bl_q  <= '0;
      bt_q  <= 1'b0;
      drv_q <= '0;
    end else if (cap_q) begin
      cap_q <= 1'b0;
      bl_q  <= bl_fix;
      bt_q  <= bt_fix;
      drv_q <= drv_fix;
    end
  end

  // timers
  logic             gap_load, gap_zero, lock_load, lock_zero;
  logic [CNT_W-1:0] gap_val;

  boot_timer #(.W(CNT_W), .RST_VAL(CNT_W'(STABLE_CYC - 1))) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load), .val_i(gap_val), .zero_o(gap_zero));

  boot_timer #(.W(CNT_W), .RST_VAL('0)) u_lock (
    .clk(clk), .rst_n(rst_n), .load_i(lock_load), .val_i(CNT_W'(LOCK_CYC - 1)), .zero_o(lock_zero));

  // word encoder
  word_e             word_sel;
  logic [ADDR_W-1:0] enc_addr;
  logic [BA_W-1:0]   enc_ba;

  boot_mode_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .sel_i(word_sel), .bl_i(bl_q), .bt_i(bt_q), .drv_i(drv_q),
    .addr_o(enc_addr), .ba_o(enc_ba));

  // sequencer
  boot_state_e       st_q, st_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic [3:0]        cmd_q, cmd_d;
  logic              cke_q, cke_d, done_q, done_d, use_word;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BA_W-1:0]   ba_q, ba_d;

  always_comb begin
    st_d      = st_q;
    ref_d     = ref_q;
    cmd_d     = CMD_NOP;
    cke_d     = cke_q;
    done_d    = done_q;
    use_word  = 1'b0;
    word_sel  = W_PRE;
    gap_load  = 1'b0;
    gap_val   = '0;
    lock_load = 1'b0;
    unique case (st_q)
      ST_STABLE: if (gap_zero) begin
        cke_d = 1'b1; st_d = ST_PRE1; gap_load = 1'b1;
      end
      ST_PRE1: if (gap_zero) begin
        cmd_d = CMD_PRE; use_word = 1'b1; word_sel = W_PRE;
        gap_load = 1'b1; gap_val = CNT_W'(T_RP - 1); st_d = ST_EXT;
      end
      ST_EXT: if (gap_zero) begin
        cmd_d = CMD_MRS; use_word = 1'b1; word_sel = W_EXT;
        gap_load = 1'b1; gap_val = CNT_W'(T_MRD - 1); st_d = ST_MODE_RST;
      end
      ST_MODE_RST: if (gap_zero) begin
        cmd_d = CMD_MRS; use_word = 1'b1; word_sel = W_MODE_RST; lock_load = 1'b1;
        gap_load = 1'b1; gap_val = CNT_W'(T_MRD - 1); st_d = ST_PRE2;
      end
      ST_PRE2: if (gap_zero) begin
        cmd_d = CMD_PRE; use_word = 1'b1; word_sel = W_PRE; ref_d = '0;
        gap_load = 1'b1; gap_val = CNT_W'(T_RP - 1); st_d = ST_REFRESH;
      end
      ST_REFRESH: if (gap_zero) begin
        cmd_d = CMD_REF; ref_d = ref_q + REF_W'(1);
        gap_load = 1'b1; gap_val = CNT_W'(T_RFC - 1);
        if (ref_q == REF_W'(N_REF - 1)) st_d = ST_MODE_RUN;
      end
      ST_MODE_RUN: if (gap_zero) begin
        cmd_d = CMD_MRS; use_word = 1'b1; word_sel = W_MODE_RUN;
        gap_load = 1'b1; gap_val = CNT_W'(T_MRD - 1); st_d = ST_LOCK;
      end
      ST_LOCK: if (gap_zero && lock_zero) begin
        done_d = 1'b1; st_d = ST_DONE;
      end
      ST_DONE: if (relock_req) begin
        done_d = 1'b0; gap_load = 1'b1; st_d = ST_MODE_RST;
      end
      default: st_d = ST_STABLE;
    endcase
    addr_d = use_word ? enc_addr : '0;
    ba_d   = use_word ? enc_ba   : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_STABLE;
      ref_q  <= '0;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      cmd_q  <= cmd_d;
      cke_q  <= cke_d;
      done_q <= done_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_cke   = cke_q;
  assign mem_addr  = addr_q;
  assign mem_ba    = ba_q;
  assign init_done = done_q;

  // checks on the pin-side behaviour
  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> (cmd_q == CMD_NOP)) else $error("cke low with command"); // R2
  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke) else $error("cke dropped"); // R2
  AST_DONE_ONLY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (mem_cke && cmd_q == CMD_NOP)) else $error("command while done"); // R8
  AST_MODE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS && mem_ba == '0) |-> (mem_addr[6:4] == 3'b011 && !mem_addr[7] && mem_addr[ADDR_W-1:9] == '0))
    else $error("bad mode word"); // R6
  AST_EXT_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS && mem_ba == BA_W'(1)) |-> (!mem_addr[0] && !(mem_addr[6] && mem_addr[1])))
    else $error("bad extended word"); // R5
  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS && mem_ba == '0) |-> (mem_addr[2:0] != 3'd0 && mem_addr[2:0] <= 3'd3))
    else $error("illegal burst length emitted"); // R7
  AST_DONE_FALL_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> $past(relock_req)) else $error("done dropped without request"); // R10

endmodule

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb_top;

  localparam int PER_PS = 10000;
  localparam int ST_US  = 2;
  localparam int S      = (ST_US * 1000000 + PER_PS - 1) / PER_PS;
  localparam int RP = 4, RFC = 14, MRD = 2, LOCK = 200, NREF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic relock = 1'b0;
  logic [2:0] bl = 3'd0;
  logic bt = 1'b0;
  logic [1:0] drv = 2'd0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [12:0] addr;

  always #5 clk = ~clk;

  sdram_boot_seq #(.CLK_PERIOD_PS(PER_PS), .STABLE_US(ST_US), .T_RP(RP), .T_RFC(RFC),
                   .T_MRD(MRD), .LOCK_CYC(LOCK), .N_REF(NREF)) dut_i (
    .clk(clk), .rst_n(rst_n), .relock_req(relock), .cfg_burst_len(bl), .cfg_burst_ilv(bt),
    .cfg_drive(drv), .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
    .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr), .init_done(done));

  typedef struct {
    int at; logic [3:0] cmd; logic [1:0] ba; logic [12:0] addr; string tag;
  } ev_t;

  ev_t evq[$];
  int  t, cke_t, done_t, errs = 0, checks = 0;
  logic [2:0] m_bl;
  logic m_bt;
  logic [1:0] m_drv;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  function automatic logic [12:0] mode_word(bit dll);
    return {4'b0, dll, 1'b0, 3'b011, m_bt, m_bl};
  endfunction

  task automatic push(int at, logic [3:0] c, logic [1:0] b, logic [12:0] a, string tag);
    ev_t e;
    e.at = at; e.cmd = c; e.ba = b; e.addr = a; e.tag = tag;
    evq.push_back(e);
  endtask

  // DLL-reset write at r, then precharge, refreshes, final write (R4, R6, R8)
  task automatic tail(int r);
    int x;
    push(r, 4'b0000, 2'b00, mode_word(1'b1), "R6");
    push(r + MRD, 4'b0010, 2'b00, 13'h400, "R4");
    x = r + MRD + RP;
    for (int i = 0; i < NREF; i++) begin
      push(x, 4'b0001, 2'b00, 13'h0, "R4");
      x += RFC;
    end
    push(x, 4'b0000, 2'b00, mode_word(1'b0), "R6");
    done_t = (x + MRD > r + LOCK) ? x + MRD : r + LOCK;
  endtask

  task automatic compare(string scen);
    ev_t e;
    e.at = t; e.cmd = 4'b0111; e.ba = 2'b00; e.addr = 13'h0; e.tag = "R3";
    if (evq.size() > 0 && evq[0].at == t) e = evq.pop_front();
    chk({"R2 ", scen}, int'(cke), int'(t >= cke_t));
    chk({e.tag, " cmd ", scen}, int'({cs_n, ras_n, cas_n, we_n}), int'(e.cmd));
    chk({e.tag, " ba ", scen}, int'(ba), int'(e.ba));
    chk({e.tag, " addr ", scen}, int'(addr), int'(e.addr));
    chk({"R8 done ", scen}, int'(done), int'(t >= done_t));
  endtask

  task automatic tick(string scen);
    @(posedge clk);
    t++;
    #2;
    compare(scen);
  endtask

  task automatic run(logic [2:0] b, logic i, logic [1:0] d, string scen,
                     bit wiggle, bit early_relock, bit late_relock);
    rst_n = 1'b0; relock = 1'b0; bl = b; bt = i; drv = d;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 cke", int'(cke), 0);
    chk("R1 cmd", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk("R1 addr", int'(addr), 0);
    chk("R1 ba", int'(ba), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    t = 0;
    evq.delete();
    m_bl  = (b == 3'd1 || b == 3'd2 || b == 3'd3) ? b : 3'd2;   // R7
    m_bt  = (b == 3'd1 || b == 3'd2 || b == 3'd3) ? i : 1'b0;
    m_drv = (d == 2'b11) ? 2'b00 : d;                          // R5
    cke_t = S;
    push(S + 1, 4'b0010, 2'b00, 13'h400, "R4");
    push(S + 1 + RP, 4'b0000, 2'b01, {6'b0, m_drv[1], 4'b0, m_drv[0], 1'b0}, "R5");
    tail(S + 1 + RP + MRD);
    while (t < done_t + 5) begin
      tick(scen);
      if (wiggle && t == 1) begin       // R9: late config changes
        bl = ~b; bt = ~i; drv = ~d;
      end
      if (early_relock && t == S + 20) relock = 1'b1;   // R11
      if (early_relock && t == S + 21) relock = 1'b0;
    end
    if (late_relock) begin              // R10
      relock = 1'b1;
      tail(t + 2);
      tick({scen, " R10"});
      relock = 1'b0;
      while (t < done_t + 5) tick({scen, " R10"});
    end
  endtask

  initial begin
    run(3'd3, 1'b1, 2'b10, "R4 bl8 ilv", 1'b0, 1'b1, 1'b1);
    run(3'd0, 1'b1, 2'b11, "R7 illegal", 1'b0, 1'b0, 1'b0);
    run(3'd5, 1'b0, 2'b01, "R7 bl5", 1'b1, 1'b0, 1'b0);
    run(3'd1, 1'b0, 2'b01, "R9 bl2", 1'b1, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1500000;
    errs++;
    $display("FAIL watchdog t=%0d actual=hung expected=finished", t);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule